// File: doc/BRIEF.md
# Embedded CPU Debug and Interrupt Control Unit

This unit sits next to a small 32-bit processor core. It gives software a register window onto the core's program counter, onto the instruction waiting in decode, and onto the interrupt vector, the hardware breakpoint and the interrupt enable. Each cycle it takes the word address and valid flag of the instruction in decode, together with the instruction itself and one interrupt line. From these it produces a halt request, a PC-load strobe with its target, a pipeline flush and an instruction-replacement path.

Writing the interrupt-enable register sets the enable bit in the mode register, whatever the data. An interrupt handler can therefore return using two general registers: one holds the saved return address, the other holds the address of this register. The handler jumps back and stores to the enable register in the delay slot. Taking an interrupt clears the enable bit and records the return PC, so interrupts cannot nest until software enables them again. Interrupts can only be disabled through the mode register.

Word offsets on the register bus are: 0 mode, 1 stop state, 2 PC, 3 instruction, 4 interrupt enable, 5 interrupt vector, 6 breakpoint, 7 saved PC.

Top module: `cpu_dbg_ctrl`

## Requirements
- R1: After reset the unit is not halted, interrupts are disabled, pc_load/flush/instr_repl_valid are low, the mode register reads 0 and the breakpoint register reads 0x1 (disabled).
- R2: The PC register (offset 2) always reads the decode word address shifted left by two, with bits 1:0 reading 0.
- R3: A PC write while halted raises pc_load and flush on the following cycle, for exactly one cycle, with pc_load_addr equal to the write data with bits 1:0 forced to 0.
- R4: A PC write while the core runs is ignored: pc_load stays low.
- R5: Any write to the interrupt-enable register (offset 4) sets mode bit 7, whatever the data; the register always reads 0.
- R6: Writing the mode register (offset 0) with bit 7 clear disables interrupts; bit 0 of the mode register is the halt bit.
- R7: When irq_in is high, mode bit 7 is set, the core is running and decode holds a valid instruction, the next cycle pulses pc_load and flush to the vector register (offset 5, bits 1:0 reading 0). The same edge clears mode bit 7 and stores the aligned decode PC in the saved-PC register (offset 7). No interrupt is taken while halted or while disabled.
- R8: With breakpoint bit 0 (disable) clear, a valid decode word address equal to breakpoint bits 31:2 halts the core on the next cycle and sets stop-state bit 1; with the disable bit set, or at any other address, nothing happens.
- R9: After resuming from a breakpoint at the same PC, that breakpoint does not fire again until decode has held a valid different address; afterwards it fires again.
- R10: The instruction register (offset 3) reads the decode instruction; a write while halted replaces it (instr_repl_valid high, readback shows the new value); the replacement stays visible for the first running cycle after resume and is then dropped; a write while running is ignored.
- R11: Setting mode bit 0 while running halts the core and sets stop-state bit 0; clearing mode bit 0 resumes; stop-state bits stay set until written with 1 (write-one-to-clear).
- R12: A breakpoint hit and an interrupt in the same cycle resolve to the halt: no PC load and interrupts stay enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| core_pc_word | input | 30 | Word address of the decode-stage instruction |
| core_valid | input | 1 | Decode stage holds a valid instruction |
| core_instr | input | 32 | Decode-stage instruction |
| irq_in | input | 1 | Level interrupt request |
| halt | output | 1 | Halt request to the core |
| pc_load | output | 1 | Load pc_load_addr into the fetch PC |
| pc_load_addr | output | 32 | PC load target, bits 1:0 zero |
| flush | output | 1 | Discard the instruction in decode |
| irq_en | output | 1 | Mode bit 7, interrupts enabled |
| instr_repl_valid | output | 1 | Replacement instruction present |
| instr_repl_data | output | 32 | Replacement instruction |

## Verification
The hardest case to reach from the ports is the return from a breakpoint. The PC still equals the breakpoint address, so a naive compare would halt again at once. The bench places the decode address at the breakpoint, lets it halt, and clears the halt bit. It holds the address for a full cycle to show that no halt follows. It then moves decode away and back to show the breakpoint is armed again. It also drives a breakpoint match and an interrupt in the same cycle to check which one wins. The address is swept over neighbouring words with the breakpoint both enabled and disabled.

// File: rtl/cpu_dbg_pkg.sv
// Shared register offsets and field positions for the CPU debug/interrupt unit.
package cpu_dbg_pkg;
    localparam int REG_AW     = 3;
    localparam int ALIGN_BITS = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_MODE  = 3'd0,
        RA_STATE = 3'd1,
        RA_PC    = 3'd2,
        RA_INSTR = 3'd3,
        RA_IEN   = 3'd4,
        RA_IVEC  = 3'd5,
        RA_BKPT  = 3'd6,
        RA_SAVED = 3'd7
    } reg_addr_e;

    localparam int MODE_HALT_BIT = 0;
    localparam int MODE_IEN_BIT  = 7;
    localparam int STOP_SW_BIT   = 0;
    localparam int STOP_BKPT_BIT = 1;
    localparam int STOP_W        = 2;
    localparam int BKPT_DIS_BIT  = 0;
endpackage

// File: rtl/dbg_bkpt_match.sv
// Hardware breakpoint register and PC comparator.
// Assumes: core_pc_word is the word address of the instruction in decode.
// A hit is suppressed after a breakpoint halt until decode shows a
// different valid address, so resuming at the breakpoint does not re-halt.
module dbg_bkpt_match #(
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bkpt_wr,
    input  logic [WORD_W-1:0] bkpt_wr_word,
    input  logic              bkpt_wr_dis,
    input  logic              halted,
    input  logic [WORD_W-1:0] core_pc_word,
    input  logic              core_valid,
    output logic              bkpt_hit,
    output logic [WORD_W-1:0] bkpt_word,
    output logic              bkpt_dis
);
    logic skip_q;
    logic addr_eq;

    assign addr_eq  = (core_pc_word == bkpt_word);
    assign bkpt_hit = core_valid && !bkpt_dis && addr_eq && !halted && !skip_q;

    // Breakpoint address and disable bit, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bkpt_word <= '0;
            bkpt_dis  <= 1'b1;
        end else if (bkpt_wr) begin
            bkpt_word <= bkpt_wr_word;
            bkpt_dis  <= bkpt_wr_dis;
        end
    end

    // Step-over flag: armed by a hit, cleared once decode leaves the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
        end else if (bkpt_wr) begin
            skip_q <= 1'b0;
        end else if (bkpt_hit) begin
            skip_q <= 1'b1;
        end else if (core_valid && !addr_eq) begin
            skip_q <= 1'b0;
        end
    end

    // R9
    no_rehit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit |=> !bkpt_hit);
endmodule

// File: rtl/dbg_irq_ctl.sv
// Interrupt enable, vector and saved-PC registers plus the take decision.
// Assumes: an interrupt is taken only while running with a valid decode
// instruction; a breakpoint hit in the same cycle wins.
module dbg_irq_ctl #(
    parameter int WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_set,
    input  logic              mode_wr,
    input  logic              mode_ien_wdata,
    input  logic              ivec_wr,
    input  logic [WORD_W-1:0] ivec_wr_word,
    input  logic              irq_in,
    input  logic              core_valid,
    input  logic [WORD_W-1:0] core_pc_word,
    input  logic              halted,
    input  logic              bkpt_hit,
    output logic              irq_en,
    output logic              irq_take,
    output logic [WORD_W-1:0] ivec_word,
    output logic [WORD_W-1:0] saved_word
);
    assign irq_take = irq_in && irq_en && core_valid && !halted && !bkpt_hit;

    // Mode bit 7: cleared on take, set by any enable-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (irq_take) begin
            irq_en <= 1'b0;
        end else if (ien_set) begin
            irq_en <= 1'b1;
        end else if (mode_wr) begin
            irq_en <= mode_ien_wdata;
        end
    end

    // Vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivec_word <= '0;
        end else if (ivec_wr) begin
            ivec_word <= ivec_wr_word;
        end
    end

    // Return address captured when an interrupt is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_word <= '0;
        end else if (irq_take) begin
            saved_word <= core_pc_word;
        end
    end

    // R7
    take_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_en && (saved_word == $past(core_pc_word)));
    // R5
    ien_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_set && !irq_take) |=> irq_en);
    // R6
    mode_clear_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !mode_ien_wdata) |=> !irq_en);
endmodule

// File: rtl/dbg_halt_ctl.sv
// Halt bit, stop-reason register, PC-write gating and decode instruction
// replacement. Assumes: the core holds its decode stage while halt is high
// and consumes a pending replacement in its first running cycle.
module dbg_halt_ctl
    import cpu_dbg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_halt_wdata,
    input  logic              state_wr,
    input  logic [STOP_W-1:0] state_w1c,
    input  logic              bkpt_hit,
    input  logic              pc_wr,
    input  logic              instr_wr,
    input  logic [DATA_W-1:0] instr_wdata,
    input  logic [DATA_W-1:0] core_instr,
    output logic              halted,
    output logic [STOP_W-1:0] stop_reason,
    output logic              pc_load_req,
    output logic              repl_valid,
    output logic [DATA_W-1:0] repl_data,
    output logic [DATA_W-1:0] instr_view
);
    logic [STOP_W-1:0] stop_set;

    assign pc_load_req = pc_wr && halted;
    assign instr_view  = repl_valid ? repl_data : core_instr;

    always_comb begin
        stop_set                = '0;
        stop_set[STOP_SW_BIT]   = mode_wr && mode_halt_wdata && !halted;
        stop_set[STOP_BKPT_BIT] = bkpt_hit;
    end

    // Halt bit: breakpoint forces it, software writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (bkpt_hit) begin
            halted <= 1'b1;
        end else if (mode_wr) begin
            halted <= mode_halt_wdata;
        end
    end

    // Stop reasons: set by events, cleared by write-one; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_reason <= '0;
        end else begin
            stop_reason <= (stop_reason & ~(state_wr ? state_w1c : '0)) | stop_set;
        end
    end

    // Replacement instruction: loaded while halted, dropped after resume or PC load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            repl_valid <= 1'b0;
            repl_data  <= '0;
        end else if (!halted || pc_load_req) begin
            repl_valid <= 1'b0;
        end else if (instr_wr) begin
            repl_valid <= 1'b1;
            repl_data  <= instr_wdata;
        end
    end

    // R8
    bkpt_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit |=> halted && stop_reason[STOP_BKPT_BIT]);
    // R10
    run_instr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && instr_wr) |=> !repl_valid);
    // R11
    stop_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_reason[STOP_SW_BIT] && !state_wr) |=> stop_reason[STOP_SW_BIT]);
endmodule

// File: rtl/cpu_dbg_ctrl.sv
// CPU debug and interrupt control unit: register decode, read mux and the
// registered PC-load/flush strobes. Assumes a single-cycle register bus with
// combinational read data and a core that obeys halt, pc_load and flush.
module cpu_dbg_ctrl
    import cpu_dbg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-ALIGN_BITS-1:0] core_pc_word,
    input  logic              core_valid,
    input  logic [DATA_W-1:0] core_instr,
    input  logic              irq_in,
    output logic              halt,
    output logic              pc_load,
    output logic [DATA_W-1:0] pc_load_addr,
    output logic              flush,
    output logic              irq_en,
    output logic              instr_repl_valid,
    output logic [DATA_W-1:0] instr_repl_data
);
    localparam int WORD_W = DATA_W - ALIGN_BITS;
    localparam logic [ALIGN_BITS-1:0] ZERO_LOW = '0;

    logic [REG_AW-1:0] wr_sel;
    logic mode_wr, state_wr, pc_wr, instr_wr, ien_wr, ivec_wr, bkpt_wr;
    logic bkpt_hit, irq_take, pc_load_req;
    logic bkpt_dis;
    logic [WORD_W-1:0] bkpt_word, ivec_word, saved_word;
    logic [STOP_W-1:0] stop_reason;
    logic [DATA_W-1:0] instr_view;
    logic [WORD_W-1:0] wdata_word;

    assign wr_sel     = reg_wr ? reg_addr : '0;
    assign mode_wr    = reg_wr && (reg_addr == RA_MODE);
    assign state_wr   = reg_wr && (reg_addr == RA_STATE);
    assign pc_wr      = reg_wr && (reg_addr == RA_PC);
    assign instr_wr   = reg_wr && (reg_addr == RA_INSTR);
    assign ien_wr     = reg_wr && (reg_addr == RA_IEN);
    assign ivec_wr    = reg_wr && (reg_addr == RA_IVEC);
    assign bkpt_wr    = reg_wr && (wr_sel == RA_BKPT);
    assign wdata_word = reg_wdata[DATA_W-1:ALIGN_BITS];

    dbg_bkpt_match #(.WORD_W(WORD_W)) u_bkpt (
        .clk          (clk),
        .rst_n        (rst_n),
        .bkpt_wr      (bkpt_wr),
        .bkpt_wr_word (wdata_word),
        .bkpt_wr_dis  (reg_wdata[BKPT_DIS_BIT]),
        .halted       (halt),
        .core_pc_word (core_pc_word),
        .core_valid   (core_valid),
        .bkpt_hit     (bkpt_hit),
        .bkpt_word    (bkpt_word),
        .bkpt_dis     (bkpt_dis)
    );

    dbg_irq_ctl #(.WORD_W(WORD_W)) u_irq (
        .clk            (clk),
        .rst_n          (rst_n),
        .ien_set        (ien_wr),
        .mode_wr        (mode_wr),
        .mode_ien_wdata (reg_wdata[MODE_IEN_BIT]),
        .ivec_wr        (ivec_wr),
        .ivec_wr_word   (wdata_word),
        .irq_in         (irq_in),
        .core_valid     (core_valid),
        .core_pc_word   (core_pc_word),
        .halted         (halt),
        .bkpt_hit       (bkpt_hit),
        .irq_en         (irq_en),
        .irq_take       (irq_take),
        .ivec_word      (ivec_word),
        .saved_word     (saved_word)
    );

    dbg_halt_ctl #(.DATA_W(DATA_W)) u_halt (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode_wr         (mode_wr),
        .mode_halt_wdata (reg_wdata[MODE_HALT_BIT]),
        .state_wr        (state_wr),
        .state_w1c       (reg_wdata[STOP_W-1:0]),
        .bkpt_hit        (bkpt_hit),
        .pc_wr           (pc_wr),
        .instr_wr        (instr_wr),
        .instr_wdata     (reg_wdata),
        .core_instr      (core_instr),
        .halted          (halt),
        .stop_reason     (stop_reason),
        .pc_load_req     (pc_load_req),
        .repl_valid      (instr_repl_valid),
        .repl_data       (instr_repl_data),
        .instr_view      (instr_view)
    );

    // PC-load strobe and target: interrupt vector or debugger PC write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_load      <= 1'b0;
            pc_load_addr <= '0;
        end else begin
            pc_load      <= irq_take || pc_load_req;
            pc_load_addr <= irq_take ? {ivec_word, ZERO_LOW} : {wdata_word, ZERO_LOW};
        end
    end

    assign flush = pc_load;

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MODE: begin
                reg_rdata[MODE_HALT_BIT] = halt;
                reg_rdata[MODE_IEN_BIT]  = irq_en;
            end
            RA_STATE: reg_rdata[STOP_W-1:0] = stop_reason;
            RA_PC:    reg_rdata = {core_pc_word, ZERO_LOW};
            RA_INSTR: reg_rdata = instr_view;
            RA_IEN:   reg_rdata = '0;
            RA_IVEC:  reg_rdata = {ivec_word, ZERO_LOW};
            RA_BKPT:  begin
                reg_rdata[DATA_W-1:ALIGN_BITS] = bkpt_word;
                reg_rdata[BKPT_DIS_BIT]        = bkpt_dis;
            end
            RA_SAVED: reg_rdata = {saved_word, ZERO_LOW};
            default:  reg_rdata = '0;
        endcase
    end

    // R4
    run_pc_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && !halt && !irq_take) |=> !pc_load);
    // R7
    take_loads_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> pc_load && flush && (pc_load_addr == {$past(ivec_word), ZERO_LOW}));
    // R3
    pc_load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && halt) |=> !pc_load);
    // R12
    bkpt_beats_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_hit && irq_in && irq_en) |=> !pc_load && irq_en);
endmodule

// File: tb/test_cpu_dbg_ctrl.sv
`timescale 1ns/1ps
module test_cpu_dbg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [29:0] core_pc_word;
    logic        core_valid;
    logic [31:0] core_instr;
    logic        irq_in;
    logic        halt, pc_load, flush, irq_en, instr_repl_valid;
    logic [31:0] pc_load_addr, instr_repl_data;

    int total = 0;
    int fails = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    cpu_dbg_ctrl i_cpu_dbg_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_pc_word(core_pc_word),
        .core_valid(core_valid), .core_instr(core_instr), .irq_in(irq_in),
        .halt(halt), .pc_load(pc_load), .pc_load_addr(pc_load_addr), .flush(flush),
        .irq_en(irq_en), .instr_repl_valid(instr_repl_valid),
        .instr_repl_data(instr_repl_data)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        core_pc_word = 30'h40; core_valid = 1'b1; core_instr = 32'hDEADBEEF; irq_in = 1'b0;
        repeat (3) step();
        // R1 reset state
        chk("R1 halt", {31'd0, halt}, 32'd0);
        chk("R1 pc_load", {31'd0, pc_load}, 32'd0);
        chk("R1 flush", {31'd0, flush}, 32'd0);
        chk("R1 irq_en", {31'd0, irq_en}, 32'd0);
        chk("R1 repl", {31'd0, instr_repl_valid}, 32'd0);
        rst_n = 1'b1;
        step();
        rd(3'd0, rv); chk("R1 mode", rv, 32'd0);
        rd(3'd6, rv); chk("R1 bkpt", rv, 32'd1);

        // R2 PC readback sweep
        for (int i = 0; i < 8; i++) begin
            core_pc_word = 30'h1000 + 30'(i * 37);
            rd(3'd2, rv);
            chk("R2 pc read", rv, {core_pc_word, 2'b00});
        end
        core_pc_word = 30'h40;

        // R11 halt via mode, R3 PC writes while halted
        wr(3'd0, 32'h1);
        chk("R11 halted", {31'd0, halt}, 32'd1);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] d;
            d = 32'h4000 + 32'(i * 16) + 32'(i);
            wr(3'd2, d);
            chk("R3 pc_load", {31'd0, pc_load}, 32'd1);
            chk("R3 flush", {31'd0, flush}, 32'd1);
            chk("R3 addr", pc_load_addr, d & 32'hFFFF_FFFC);
            step();
            chk("R3 one cycle", {31'd0, pc_load}, 32'd0);
        end
        rd(3'd1, rv); chk("R11 sw reason", rv, 32'd1);
        wr(3'd0, 32'h0);
        chk("R11 resumed", {31'd0, halt}, 32'd0);
        rd(3'd1, rv); chk("R11 reason held", rv, 32'd1);
        wr(3'd1, 32'h1);
        rd(3'd1, rv); chk("R11 reason cleared", rv, 32'd0);

        // R4 PC write while running
        wr(3'd2, 32'h8888);
        chk("R4 ignored", {31'd0, pc_load}, 32'd0);

        // R10 instruction register
        rd(3'd3, rv); chk("R10 decode read", rv, 32'hDEADBEEF);
        wr(3'd3, 32'h12345678);
        chk("R10 run write ignored", {31'd0, instr_repl_valid}, 32'd0);
        rd(3'd3, rv); chk("R10 run readback", rv, 32'hDEADBEEF);
        wr(3'd0, 32'h1);
        wr(3'd3, 32'h0000000C);
        chk("R10 repl valid", {31'd0, instr_repl_valid}, 32'd1);
        chk("R10 repl data", instr_repl_data, 32'h0000000C);
        rd(3'd3, rv); chk("R10 repl readback", rv, 32'h0000000C);
        wr(3'd0, 32'h0);
        chk("R10 repl after resume", {31'd0, instr_repl_valid}, 32'd1);
        step();
        chk("R10 repl dropped", {31'd0, instr_repl_valid}, 32'd0);
        wr(3'd1, 32'h3);

        // R5 / R6 enable register sweep over data patterns
        for (int i = 0; i < 4; i++) begin
            logic [31:0] d;
            d = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : (i == 2) ? 32'h1 : 32'h80;
            wr(3'd0, 32'h0);
            rd(3'd0, rv); chk("R6 disabled", rv, 32'd0);
            wr(3'd4, d);
            rd(3'd0, rv); chk("R5 enabled", rv, 32'h80);
            rd(3'd4, rv); chk("R5 reads zero", rv, 32'd0);
        end

        // R7 interrupt take
        wr(3'd5, 32'h2003);
        rd(3'd5, rv); chk("R7 vector read", rv, 32'h2000);
        core_pc_word = 30'h100;
        irq_in = 1'b1;
        step();
        chk("R7 pc_load", {31'd0, pc_load}, 32'd1);
        chk("R7 flush", {31'd0, flush}, 32'd1);
        chk("R7 target", pc_load_addr, 32'h2000);
        rd(3'd0, rv); chk("R7 enable cleared", rv, 32'd0);
        rd(3'd7, rv); chk("R7 saved pc", rv, 32'h400);
        step();
        chk("R7 no nesting", {31'd0, pc_load}, 32'd0);
        irq_in = 1'b0;
        wr(3'd0, 32'h81);
        irq_in = 1'b1;
        step();
        chk("R7 blocked halted", {31'd0, pc_load}, 32'd0);
        wr(3'd0, 32'h80);
        chk("R7 resume edge", {31'd0, pc_load}, 32'd0);
        step();
        chk("R7 taken after resume", {31'd0, pc_load}, 32'd1);
        chk("R7 target again", pc_load_addr, 32'h2000);
        irq_in = 1'b0;
        wr(3'd1, 32'h3);

        // R8 / R9 breakpoint sweep
        core_pc_word = 30'h0;
        for (int dis = 0; dis < 2; dis++) begin
            for (int k = -2; k <= 2; k++) begin
                logic exp_hit;
                wr(3'd6, 32'h600 | 32'(dis));
                core_pc_word = 30'(32'h180 + k);
                exp_hit = (dis == 0) && (k == 0);
                step();
                chk("R8 halt on match", {31'd0, halt}, {31'd0, exp_hit});
                if (exp_hit) begin
                    rd(3'd1, rv); chk("R8 bkpt reason", rv, 32'd2);
                    wr(3'd0, 32'h0);
                    chk("R9 resumed", {31'd0, halt}, 32'd0);
                    step();
                    chk("R9 no immediate rehit", {31'd0, halt}, 32'd0);
                    core_pc_word = 30'h0;
                    step();
                    core_pc_word = 30'h180;
                    step();
                    chk("R9 rearmed", {31'd0, halt}, 32'd1);
                    wr(3'd0, 32'h0);
                    core_pc_word = 30'h0;
                    step();
                    wr(3'd1, 32'h2);
                end
                core_pc_word = 30'h0;
                step();
            end
        end

        // R12 breakpoint beats interrupt
        wr(3'd6, 32'h600);
        wr(3'd4, 32'h0);
        core_pc_word = 30'h180;
        irq_in = 1'b1;
        step();
        chk("R12 halted", {31'd0, halt}, 32'd1);
        chk("R12 no load", {31'd0, pc_load}, 32'd0);
        rd(3'd0, rv); chk("R12 mode", rv, 32'h81);
        irq_in = 1'b0;
        wr(3'd0, 32'h0);
        core_pc_word = 30'h0;
        step();

        finish_run();
    end
endmodule